// File: doc/BRIEF.md
# Boost PFC Fault and Operating-Mode Supervisor

This block watches a digitally controlled boost power-factor stage and decides, once per clock, whether the power switch may be driven. It reads two digitized ratios and several flags. The first ratio is the output voltage relative to its regulation target. The second is the rectified line voltage relative to its nominal level. The flags are an overpower indication, an over-temperature indication, an active-low standby request, a light-load indication and a line-cycle marker. All time qualification runs from a 1 ms tick enable.

The block has three outputs. The first is a gate-enable for the pulse generator downstream. The second is an operating mode: start-up, normal or burst. The third is a status code that names the highest-priority reason the gate is held off. Fault paths with their own timing can overlap:

- hysteretic comparators for overvoltage and for the start-up region;
- separate timers for entering and leaving brownout;
- an overpower timer that leads to a long hiccup off-time.

A fixed priority resolves these paths into one code. Both ratios use the scale where the parameter NOM (default 512) means 100 %. The thresholds quoted below are for the default parameters.

Top module: `pfc_supervisor`

## Requirements
- R1: Reset is synchronous and active low. Once reset is released with clean inputs, mode is start-up (code 0), status is 0 (run) and gate_en is 1.
- R2: Mode codes are 0 start-up, 1 normal and 2 burst; code 3 never appears. A vout_ratio below 435 moves mode to start-up one clock later. From start-up, mode moves to normal one clock after vout_ratio is 486 or more. A value from 435 to 485 leaves the current mode unchanged.
- R3: A vout_ratio above 547 sets overvoltage (status 5, gate off) one clock later. Overvoltage clears only after vout_ratio is 527 or less.
- R4: Brownout (status 4, gate off) is entered when vline_ratio is 250 or less on 56 consecutive ms ticks. A single clock with the ratio above 250 restarts the count from zero.
- R5: Brownout is left only after vline_ratio is above 288 on 56 consecutive ms ticks. A single clock at or below 288 restarts this count.
- R6: The overpower flag is counted only while mode is start-up. After 112 consecutive ticks the block enters hiccup (status 3, gate off, mode start-up) for 3000 ticks. After the hiccup the gate returns, and the sequence repeats while the flag persists.
- R7: In normal mode with light_load high, mode becomes burst one clock later. In burst, each line_sync pulse toggles between an on interval and an off interval. The first pulse after entry starts an off interval. Dropping light_load returns mode to normal with the gate on.
- R8: stby_n low gives status 1 and gate_en 0 in the same cycle, above every other cause.
- R9: overtemp high (with stby_n high) gives status 2 and gate off. Switching resumes as soon as the flag drops.
- R10: status reports the highest active cause in the order standby(1), over-temperature(2), hiccup(3), brownout(4), overvoltage(5). gate_en is 1 only when status is 0 and no burst off interval is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| vout_ratio | input | RW | Output voltage ratio, NOM = 100 % |
| vline_ratio | input | RW | Rectified line ratio, NOM = 100 % |
| overpower | input | 1 | Estimated power above its limit |
| overtemp | input | 1 | Die temperature too high (hysteresis applied upstream) |
| stby_n | input | 1 | Active-low standby request |
| light_load | input | 1 | Estimated power below 5 % of nominal |
| line_sync | input | 1 | One-cycle pulse at each line-cycle boundary |
| gate_en | output | 1 | Power switch may be driven |
| mode | output | 2 | 0 start-up, 1 normal, 2 burst |
| status | output | 3 | Highest active gate-off cause, 0 when none |

## Verification
The bench probes each hysteresis band at both of its edges. If the set and clear levels were swapped, or a comparison used the wrong strictness, overvoltage would release at 528 or the start-up region would capture 435. For both brownout timers, the bench breaks the condition for a single clock one tick short of expiry. A timer that only paused instead of restarting would then trip early. The overpower path is driven while in normal mode to show that it is ignored there. It is then run through two full hiccup periods, which exposes an off-time that is off by one tick or a repeat that never happens. Priority is exercised by stacking standby, over-temperature and overvoltage, and then removing them one at a time.

// File: rtl/pfc_sup_pkg.sv
// Shared encodings for the PFC supervisor.
// Assumes: consumers compare outputs against these fixed code values.
package pfc_sup_pkg;

    typedef enum logic [1:0] {
        MODE_START = 2'd0,
        MODE_NORM  = 2'd1,
        MODE_BURST = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_STBY   = 3'd1,
        ST_HOT    = 3'd2,
        ST_HICCUP = 3'd3,
        ST_BROWN  = 3'd4,
        ST_OVP    = 3'd5
    } stat_e;

endpackage

// File: rtl/pfc_qual_timer.sv
// Qualification timer: raises done in the cycle that the LIMIT-th
// consecutive tick is seen while cond holds.
// Assumes: LIMIT >= 2; any cycle with cond low clears the count.
module pfc_qual_timer #(
    parameter int LIMIT = 56
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cond,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // Expiry is seen combinationally so the owner can act on the same edge.
    assign done = cond && tick && (cnt_q == CW'(LIMIT - 1));

    // Count ticks while the condition holds; clear on any break.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!cond) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (done) cnt_q <= '0;
            else      cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pfc_hyst_flag.sv
// Set/clear flag with set priority, used for every latched fault state.
// Assumes: set and clear are not asserted together in normal use.
module pfc_hyst_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Hold the flag between its set and clear events.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/pfc_mode_fsm.sv
// Operating-mode machine (start-up / normal / burst) plus burst interval phase.
// Assumes: line_sync is a one-cycle pulse per line cycle; force_start is a
// one-cycle pulse when a hiccup begins.
module pfc_mode_fsm
    import pfc_sup_pkg::*;
#(
    parameter int RW  = 10,
    parameter int NOM = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] vout_ratio,
    input  logic          light_load,
    input  logic          line_sync,
    input  logic          force_start,
    output mode_e         mode_q,
    output logic          burst_off_q
);
    localparam logic [RW-1:0] UV_TRIP = RW'(NOM * 85 / 100);
    localparam logic [RW-1:0] UV_CLR  = RW'(NOM * 95 / 100);

    mode_e mode_d;

    // Next-mode decision; a low output always wins over load-driven moves.
    always_comb begin
        mode_d = mode_q;
        if (vout_ratio < UV_TRIP || force_start) begin
            mode_d = MODE_START;
        end else begin
            unique case (mode_q)
                MODE_START: if (vout_ratio >= UV_CLR) mode_d = MODE_NORM;
                MODE_NORM:  if (light_load)           mode_d = MODE_BURST;
                MODE_BURST: if (!light_load)          mode_d = MODE_NORM;
                default:                              mode_d = MODE_START;
            endcase
        end
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_START;
        else        mode_q <= mode_d;
    end

    // Burst phase: toggles at each line-cycle boundary, cleared outside burst.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   burst_off_q <= 1'b0;
        else if (mode_q != MODE_BURST)                burst_off_q <= 1'b0;
        else if (line_sync)                           burst_off_q <= !burst_off_q;
    end
endmodule

// File: rtl/pfc_supervisor.sv
// PFC fault and mode supervisor top. Combines overvoltage hysteresis,
// brownout entry/exit timers, overpower hiccup and external standby /
// over-temperature into a gate enable, a mode and a status code.
// Assumes: all inputs are synchronous to clk; ms_tick is a 1-cycle pulse.
module pfc_supervisor
    import pfc_sup_pkg::*;
#(
    parameter int RW          = 10,
    parameter int NOM         = 512,
    parameter int BO_ENTER_MS = 56,
    parameter int BO_EXIT_MS  = 56,
    parameter int OP_QUAL_MS  = 112,
    parameter int HICCUP_MS   = 3000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ms_tick,
    input  logic [RW-1:0] vout_ratio,
    input  logic [RW-1:0] vline_ratio,
    input  logic          overpower,
    input  logic          overtemp,
    input  logic          stby_n,
    input  logic          light_load,
    input  logic          line_sync,
    output logic          gate_en,
    output logic [1:0]    mode,
    output logic [2:0]    status
);
    localparam logic [RW-1:0] OV_TRIP = RW'(NOM * 107 / 100);
    localparam logic [RW-1:0] OV_CLR  = RW'(NOM * 103 / 100);
    localparam logic [RW-1:0] BO_LO   = RW'(NOM * 49 / 100);
    localparam logic [RW-1:0] BO_HI   = RW'(NOM * 564 / 1000);

    mode_e mode_q;
    logic  burst_off_q;
    logic  ov_q, bo_q, hic_q;
    logic  bo_in_done, bo_out_done, op_done, hic_done;
    stat_e stat_c;

    // Overvoltage latch with asymmetric set/clear levels.
    pfc_hyst_flag u_ov (
        .clk(clk), .rst_n(rst_n),
        .set_i(vout_ratio > OV_TRIP), .clr_i(vout_ratio <= OV_CLR),
        .flag_o(ov_q)
    );

    // Brownout entry qualification.
    pfc_qual_timer #(.LIMIT(BO_ENTER_MS)) u_bo_in (
        .clk(clk), .rst_n(rst_n), .tick(ms_tick),
        .cond(!bo_q && vline_ratio <= BO_LO), .done(bo_in_done)
    );

    // Brownout exit qualification.
    pfc_qual_timer #(.LIMIT(BO_EXIT_MS)) u_bo_out (
        .clk(clk), .rst_n(rst_n), .tick(ms_tick),
        .cond(bo_q && vline_ratio > BO_HI), .done(bo_out_done)
    );

    // Brownout state.
    pfc_hyst_flag u_bo (
        .clk(clk), .rst_n(rst_n),
        .set_i(bo_in_done), .clr_i(bo_out_done), .flag_o(bo_q)
    );

    // Overpower persistence, counted only in start-up and outside hiccup.
    pfc_qual_timer #(.LIMIT(OP_QUAL_MS)) u_op (
        .clk(clk), .rst_n(rst_n), .tick(ms_tick),
        .cond(overpower && mode_q == MODE_START && !hic_q), .done(op_done)
    );

    // Hiccup off-time length.
    pfc_qual_timer #(.LIMIT(HICCUP_MS)) u_hic_len (
        .clk(clk), .rst_n(rst_n), .tick(ms_tick),
        .cond(hic_q), .done(hic_done)
    );

    // Hiccup state.
    pfc_hyst_flag u_hic (
        .clk(clk), .rst_n(rst_n),
        .set_i(op_done), .clr_i(hic_done), .flag_o(hic_q)
    );

    pfc_mode_fsm #(.RW(RW), .NOM(NOM)) u_mode (
        .clk(clk), .rst_n(rst_n), .vout_ratio(vout_ratio),
        .light_load(light_load), .line_sync(line_sync),
        .force_start(op_done), .mode_q(mode_q), .burst_off_q(burst_off_q)
    );

    // Priority resolution of gate-off causes.
    always_comb begin
        if (!stby_n)       stat_c = ST_STBY;
        else if (overtemp) stat_c = ST_HOT;
        else if (hic_q)    stat_c = ST_HICCUP;
        else if (bo_q)     stat_c = ST_BROWN;
        else if (ov_q)     stat_c = ST_OVP;
        else               stat_c = ST_RUN;
    end

    assign status  = stat_c;
    assign mode    = mode_q;
    assign gate_en = (stat_c == ST_RUN) && !(mode_q == MODE_BURST && burst_off_q);
endmodule

// File: rtl/pfc_supervisor_chk.sv
// Property checker for pfc_supervisor, attached by bind.
// Assumes: observes top-level ports only.
module pfc_supervisor_chk #(
    parameter int RW  = 10,
    parameter int NOM = 512
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stby_n,
    input logic          overtemp,
    input logic [RW-1:0] vout_ratio,
    input logic          gate_en,
    input logic [1:0]    mode,
    input logic [2:0]    status
);
    localparam logic [RW-1:0] UV_TRIP = RW'(NOM * 85 / 100);

    a_r2_uv_forces_startup: assert property (@(posedge clk) disable iff (!rst_n)
        (vout_ratio < UV_TRIP) |=> (mode == 2'd0));

    a_r2_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'd3);

    a_r8_standby_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !stby_n |-> (status == 3'd1 && !gate_en));

    a_r9_overtemp_status: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_n && overtemp) |-> (status == 3'd2 && !gate_en));

    a_r10_gate_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en |-> (status == 3'd0));

    a_r10_clear_not_burst_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd0 && mode != 2'd2) |-> gate_en);
endmodule

bind pfc_supervisor pfc_supervisor_chk #(.RW(RW), .NOM(NOM)) chk_i (
    .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .overtemp(overtemp),
    .vout_ratio(vout_ratio), .gate_en(gate_en), .mode(mode), .status(status)
);

// File: tb/pfc_supervisor_tb_top.sv
// Self-checking bench for pfc_supervisor.
module pfc_supervisor_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic [9:0] vout_ratio = 10'd450;
    logic [9:0] vline_ratio = 10'd400;
    logic       overpower = 1'b0;
    logic       overtemp = 1'b0;
    logic       stby_n = 1'b1;
    logic       light_load = 1'b0;
    logic       line_sync = 1'b0;
    logic       gate_en;
    logic [1:0] mode;
    logic [2:0] status;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pfc_supervisor dut_i (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
        .vout_ratio(vout_ratio), .vline_ratio(vline_ratio),
        .overpower(overpower), .overtemp(overtemp), .stby_n(stby_n),
        .light_load(light_load), .line_sync(line_sync),
        .gate_en(gate_en), .mode(mode), .status(status)
    );

    // Vector: {vout[9:0], stby_n, overtemp, exp_status[2:0], exp_gate}
    localparam logic [15:0] TBL [11] = '{
        {10'd512, 1'b1, 1'b0, 3'd0, 1'b1},
        {10'd547, 1'b1, 1'b0, 3'd0, 1'b1},
        {10'd548, 1'b1, 1'b0, 3'd5, 1'b0},
        {10'd530, 1'b1, 1'b0, 3'd5, 1'b0},
        {10'd528, 1'b1, 1'b0, 3'd5, 1'b0},
        {10'd527, 1'b1, 1'b0, 3'd0, 1'b1},
        {10'd560, 1'b0, 1'b1, 3'd1, 1'b0},
        {10'd560, 1'b1, 1'b1, 3'd2, 1'b0},
        {10'd560, 1'b1, 1'b0, 3'd5, 1'b0},
        {10'd512, 1'b1, 1'b1, 3'd2, 1'b0},
        {10'd512, 1'b1, 1'b0, 3'd0, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic sync_pulse();
        line_sync = 1'b1;
        @(negedge clk);
        line_sync = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mode", mode, 0);
        chk("R1 status", status, 0);
        chk("R1 gate", gate_en, 1);

        // R2 start-up band edges
        vout_ratio = 10'd485; @(negedge clk); chk("R2 485 stays startup", mode, 0);
        vout_ratio = 10'd486; @(negedge clk); chk("R2 486 to normal", mode, 1);
        vout_ratio = 10'd435; @(negedge clk); chk("R2 435 keeps normal", mode, 1);
        vout_ratio = 10'd434; @(negedge clk); chk("R2 434 to startup", mode, 0);
        vout_ratio = 10'd512; @(negedge clk); chk("R2 back to normal", mode, 1);

        // R3 / R8 / R9 / R10 vector walk
        for (int k = 0; k < 11; k++) begin
            vout_ratio = TBL[k][15:6];
            stby_n     = TBL[k][5];
            overtemp   = TBL[k][4];
            @(negedge clk);
            chk("R3/R8/R9/R10 status", status, int'(TBL[k][3:1]));
            chk("R10 gate", gate_en, int'(TBL[k][0]));
        end

        // R4 brownout entry with a one-cycle break
        vline_ratio = 10'd250; ticks(55); chk("R4 before expiry", status, 0);
        vline_ratio = 10'd251; @(negedge clk);
        vline_ratio = 10'd250; ticks(55); chk("R4 restart after break", status, 0);
        ticks(1); chk("R4 brownout entered", status, 4); chk("R4 gate off", gate_en, 0);

        // R5 brownout exit
        vline_ratio = 10'd288; ticks(60); chk("R5 288 not enough", status, 4);
        vline_ratio = 10'd300; ticks(55);
        vline_ratio = 10'd270; @(negedge clk);
        vline_ratio = 10'd300; ticks(55); chk("R5 restart after break", status, 4);
        ticks(1); chk("R5 brownout left", status, 0); chk("R5 gate on", gate_en, 1);

        // R6 overpower ignored in normal, then hiccup in start-up
        overpower = 1'b1; ticks(150); chk("R6 ignored in normal", status, 0);
        vout_ratio = 10'd430; @(negedge clk);
        vout_ratio = 10'd450; @(negedge clk); chk("R6 in startup", mode, 0);
        ticks(111); chk("R6 before qualify", status, 0);
        ticks(1); chk("R6 hiccup entered", status, 3); chk("R6 gate off", gate_en, 0);
        chk("R6 mode startup", mode, 0);
        ticks(2999); chk("R6 hiccup still on", status, 3);
        ticks(1); chk("R6 hiccup ended", status, 0); chk("R6 gate back", gate_en, 1);
        ticks(111); chk("R6 repeat not yet", status, 0);
        ticks(1); chk("R6 hiccup repeats", status, 3);
        overpower = 1'b0; ticks(3000); chk("R6 released", status, 0);
        ticks(200); chk("R6 stays clear", status, 0);

        // R7 burst intervals
        vout_ratio = 10'd512; @(negedge clk); chk("R7 normal", mode, 1);
        light_load = 1'b1; @(negedge clk); chk("R7 burst mode", mode, 2);
        chk("R7 on before first sync", gate_en, 1);
        sync_pulse(); chk("R7 off interval", gate_en, 0); chk("R7 status clear", status, 0);
        sync_pulse(); chk("R7 on interval", gate_en, 1);
        sync_pulse(); chk("R7 off again", gate_en, 0);
        light_load = 1'b0; @(negedge clk); chk("R7 leave burst", mode, 1);
        chk("R7 gate on after burst", gate_en, 1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule